// File: doc/BRIEF.md
# Direct-Mapped Cache with Selectable Write Policy

This block is a small direct-mapped cache controller. It sits between a CPU request port and a main-memory port whose latency is fixed. Each line holds one data word, and the cache keeps a valid bit, a dirty bit, a tag and the data for every line. The CPU holds a request with a valid/ready handshake: ready stays low while the cache stalls, and in the cycle ready is high the access completes and any read data is valid.

A mode input picks the write policy while the cache is idle. In write-through mode every write goes to memory, and a write that misses does not allocate a line. In write-back mode writes stay in the cache and mark the line dirty. A miss allocates the line, and a dirty victim is first copied back to memory. The latency of each access depends on its outcome: 1 cycle, M+1 cycles or 2M+1 cycles, where M is the memory latency parameter.

Top module: `wpol_cache`

## Requirements
- R1: The byte address is split into a line index and a tag. The index is the low IDX_W bits and the tag is the remaining high bits. Two addresses with the same index and different tags evict each other, and with the default widths 8'hD6 and 8'h16 both map to index 3'b110.
- R2: After reset every line is invalid and no line is dirty. With no request pending, cpu_ready and mem_req are low, and the first read of any address misses.
- R3: A read hit completes in 1 cycle, returns the cached word and starts no memory transaction.
- R4: A read miss whose victim is invalid or clean takes M+1 cycles. It issues one memory read, fills the line with the new tag and returns the memory word.
- R5: In write-through mode (wb_mode=0), every write takes M+1 cycles and issues one memory write. Memory holds the new value when the access completes.
- R6: A write-through write hit also updates the cached word, so the next read of that address hits in 1 cycle and returns the new value.
- R7: A write-through write miss leaves the line's valid bit, tag and data unchanged. The resident address still hits, and the written address still misses.
- R8: In write-back mode (wb_mode=1), a write hit takes 1 cycle, starts no memory transaction and leaves memory unchanged. It marks the line dirty.
- R9: In write-back mode, a miss whose victim is dirty takes 2M+1 cycles. The cache first writes the victim word to the victim's own address, then fills the line.
- R10: In write-back mode, a write miss allocates the line by filling it and then applies the write as a hit. The line ends dirty with the new tag, and the next read hits with the written value.
- R11: cpu_ready is high only while cpu_valid is high. It stays low for every stall cycle, and a read's data is valid in the cycle cpu_ready is high.
- R12: Once mem_req is raised, it stays high with stable address, direction and write data until mem_ack. Each access makes exactly the number of memory transactions its outcome calls for: 0, 1 or 2.
- R13: Switching from write-back to write-through does not clean the lines. A dirty line left over from write-back mode is still written back when a read miss replaces it, which takes 2M+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wb_mode | input | 1 | 1 = write-back with allocate, 0 = write-through without allocate; changed only while idle |
| cpu_valid | input | 1 | CPU request present; held until cpu_ready |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Access completes in this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with cpu_ready |
| mem_req | output | 1 | Memory transaction request, held until mem_ack |
| mem_we | output | 1 | 1 = memory write, 0 = memory read |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_ack | input | 1 | Memory transaction finishes this cycle |
| mem_rdata | input | DATA_W | Memory read data, valid with mem_ack |

## Verification
A directed sequence runs on a single index, which three tags contend for. It separates the outcomes in turn: a hit from a conflict miss, a write-through write hit from a write-through write miss, a write-back write hit from a clean allocation, and a dirty eviction in each mode. Each of these outcomes has its own latency, transaction count and memory image.

Random traffic over four tags per index and random write policy switches then mixes all outcomes. This exposes stale dirty state, lost write-backs and wrong fill data. A reference model of the tags, valid bits and dirty bits predicts the latency of every access, and a shadow memory predicts every read value.

// File: rtl/wpol_pkg.sv
package wpol_pkg;
  // Controller phases; the memory phases each hold one memory transaction
  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WRT   = 3'd1,  // write-through store to memory
    PH_EVICT = 3'd2,  // copy dirty victim to memory
    PH_FILL  = 3'd3,  // read line from memory
    PH_DONE  = 3'd4   // completion cycle after a memory phase
  } phase_t;
endpackage

// File: rtl/wpol_rst_sync.sv
module wpol_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/wpol_lines.sv
module wpol_lines #(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  input  logic [TAG_W-1:0]  tag_in,
  input  logic              fill_en,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              upd_en,
  input  logic [DATA_W-1:0] upd_data,
  input  logic              dirty_set,
  output logic              l_vld,
  output logic              l_drt,
  output logic [TAG_W-1:0]  l_tag,
  output logic [DATA_W-1:0] l_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0] vld_vec;
  logic [LINES-1:0] drt_vec;
  logic [TAG_W-1:0]  tag_arr [LINES];
  logic [DATA_W-1:0] dat_arr [LINES];

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              sel;
    logic              vld_q;
    logic              drt_q;
    logic              flag_en;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] dat_q;

    assign sel     = (idx == IDX_W'(g));
    assign flag_en = sel && (fill_en || dirty_set);

    // status bits: reset to a known empty state
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q <= 1'b0;
        drt_q <= 1'b0;
      end else if (flag_en) begin
        vld_q <= 1'b1;
        drt_q <= dirty_set;
      end
    end

    // tag and data: no reset, qualified by valid
    always_ff @(posedge clk) begin
      if (sel && fill_en) tag_q <= tag_in;
    end

    always_ff @(posedge clk) begin
      if (sel && (fill_en || upd_en)) dat_q <= upd_en ? upd_data : fill_data;
    end

    assign vld_vec[g] = vld_q;
    assign drt_vec[g] = drt_q;
    assign tag_arr[g] = tag_q;
    assign dat_arr[g] = dat_q;
  end

  assign l_vld  = vld_vec[idx];
  assign l_drt  = drt_vec[idx];
  assign l_tag  = tag_arr[idx];
  assign l_data = dat_arr[idx];
endmodule

// File: rtl/wpol_fsm.sv
module wpol_fsm
  import wpol_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wb_mode,
  input  logic cpu_valid,
  input  logic cpu_we,
  input  logic hit,
  input  logic vic_dirty,
  input  logic mem_ack,
  output logic cpu_ready,
  output logic mem_req,
  output logic mem_we,
  output logic evict_sel,
  output logic fill_en,
  output logic upd_en,
  output logic dirty_set
);
  phase_t ph_q, ph_d, act;
  logic   idle, quick, mem_busy, ph_en;

  always_comb begin
    idle  = (ph_q == PH_IDLE);
    // one-cycle completion: read hit, or write hit under write-back
    quick = cpu_valid && hit && (!cpu_we || wb_mode);
    if (!idle)                  act = ph_q;
    else if (cpu_we && !wb_mode) act = PH_WRT;
    else if (vic_dirty)         act = PH_EVICT;
    else                        act = PH_FILL;
    mem_busy = (idle && cpu_valid && !quick) ||
               (ph_q == PH_WRT) || (ph_q == PH_EVICT) || (ph_q == PH_FILL);
  end

  always_comb begin
    ph_d = ph_q;
    if (mem_busy) begin
      if (mem_ack) ph_d = (act == PH_EVICT) ? PH_FILL : PH_DONE;
      else         ph_d = act;
    end else if (ph_q == PH_DONE) begin
      ph_d = PH_IDLE;
    end
  end

  assign ph_en = (ph_d != ph_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     ph_q <= PH_IDLE;
    else if (ph_en) ph_q <= ph_d;
  end

  assign cpu_ready = (idle && quick) || (ph_q == PH_DONE);
  assign mem_req   = mem_busy;
  assign mem_we    = mem_busy && ((act == PH_WRT) || (act == PH_EVICT));
  assign evict_sel = mem_busy && (act == PH_EVICT);
  assign fill_en   = mem_busy && mem_ack && (act == PH_FILL);
  // writes touch the line only after the tag check has confirmed a hit
  assign upd_en    = cpu_valid && cpu_we && cpu_ready && hit;
  assign dirty_set = upd_en && wb_mode;
endmodule

// File: rtl/wpol_cache.sv
module wpol_cache #(
  parameter int ADDR_W  = 8,
  parameter int IDX_W   = 3,
  parameter int DATA_W  = 8,
  parameter int MEM_LAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wb_mode,
  input  logic              cpu_valid,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic              rst_q_n;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic              l_vld, l_drt, hit, vic_dirty;
  logic [TAG_W-1:0]  l_tag;
  logic [DATA_W-1:0] l_data;
  logic              evict_sel, fill_en, upd_en, dirty_set;

  assign idx       = cpu_addr[IDX_W-1:0];
  assign tag       = cpu_addr[ADDR_W-1:IDX_W];
  assign hit       = l_vld && (l_tag == tag);
  assign vic_dirty = l_vld && l_drt;

  wpol_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  wpol_lines #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .idx       (idx),
    .tag_in    (tag),
    .fill_en   (fill_en),
    .fill_data (mem_rdata),
    .upd_en    (upd_en),
    .upd_data  (cpu_wdata),
    .dirty_set (dirty_set),
    .l_vld     (l_vld),
    .l_drt     (l_drt),
    .l_tag     (l_tag),
    .l_data    (l_data)
  );

  wpol_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_q_n),
    .wb_mode   (wb_mode),
    .cpu_valid (cpu_valid),
    .cpu_we    (cpu_we),
    .hit       (hit),
    .vic_dirty (vic_dirty),
    .mem_ack   (mem_ack),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .evict_sel (evict_sel),
    .fill_en   (fill_en),
    .upd_en    (upd_en),
    .dirty_set (dirty_set)
  );

  // victim write-back uses the stored tag; everything else the CPU address
  assign mem_addr  = evict_sel ? {l_tag, idx} : cpu_addr;
  assign mem_wdata = evict_sel ? l_data : cpu_wdata;
  assign cpu_rdata = l_data;
endmodule

// File: rtl/wpol_cache_chk.sv
module wpol_cache_chk #(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 8,
  parameter int MEM_LAT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  localparam int STALL_MAX = 2 * MEM_LAT;
  localparam int SW        = $clog2(STALL_MAX + 2) + 1;

  logic [SW-1:0] stall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      stall_q <= '0;
    else if (cpu_valid && !cpu_ready) stall_q <= stall_q + 1'b1;
    else                             stall_q <= '0;
  end

  AST_READY_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_ready |-> cpu_valid); // R11

  AST_STALL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    stall_q <= SW'(STALL_MAX)); // R9

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req); // R12

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> ($stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12

  AST_ACK_WITH_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ack |-> mem_req); // R12
endmodule

bind wpol_cache wpol_cache_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .MEM_LAT(MEM_LAT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_valid (cpu_valid),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/wpol_cache_tb.sv
module wpol_cache_tb;
  localparam int M = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wb_mode = 1'b0;
  logic       cpu_valid = 1'b0;
  logic       cpu_we = 1'b0;
  logic [7:0] cpu_addr = '0;
  logic [7:0] cpu_wdata = '0;
  logic       cpu_ready;
  logic [7:0] cpu_rdata;
  logic       mem_req, mem_we, mem_ack;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;

  int n_chk = 0;
  int n_bad = 0;
  int n_ack = 0;

  always #2 clk = ~clk;

  wpol_cache #(.ADDR_W(8), .IDX_W(3), .DATA_W(8), .MEM_LAT(M)) u_dut (
    .clk(clk), .rst_n(rst_n), .wb_mode(wb_mode),
    .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // fixed-latency memory: ack in the M-th cycle of a held request
  logic [7:0] mem [256];
  logic [7:0] shadow [256];
  int         cnt;

  assign mem_ack   = mem_req && (cnt == M - 1);
  assign mem_rdata = mem[mem_addr];

  always @(posedge clk) begin
    if (!rst_n) cnt <= 0;
    else if (mem_req) begin
      cnt <= mem_ack ? 0 : cnt + 1;
      if (mem_ack) begin
        n_ack <= n_ack + 1;
        if (mem_we) mem[mem_addr] <= mem_wdata;
      end
    end else cnt <= 0;
  end

  // reference model of the line state
  bit         m_vld [8];
  bit         m_drt [8];
  logic [4:0] m_tag [8];

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic access(input bit we, input logic [7:0] a, input logic [7:0] d, output int lat);
    int         idx = int'(a[2:0]);
    logic [4:0] tg = a[7:3];
    bit         hit = m_vld[idx] && (m_tag[idx] == tg);
    bit         vdirty = m_vld[idx] && m_drt[idx];
    logic [7:0] vaddr = {m_tag[idx], a[2:0]};
    logic [7:0] mem_before = mem[a];
    logic [7:0] got;
    int         elat, etx, tx0;
    string      rq;
    if (we && !wb_mode)  begin elat = M + 1;     etx = 1; rq = "R5"; end
    else if (hit)        begin elat = 1;         etx = 0; rq = we ? "R8" : "R3"; end
    else if (vdirty)     begin elat = 2 * M + 1; etx = 2; rq = wb_mode ? "R9" : "R13"; end
    else                 begin elat = M + 1;     etx = 1; rq = we ? "R10" : "R4"; end
    tx0 = n_ack;
    @(negedge clk);
    cpu_we = we; cpu_addr = a; cpu_wdata = d; cpu_valid = 1'b1;
    #1 lat = 1;
    while (!cpu_ready && lat < 1000) begin
      @(negedge clk); #1; lat++;
    end
    got = cpu_rdata;
    @(posedge clk); #1 cpu_valid = 1'b0;
    check(lat == elat, {rq, " latency R11"}, lat, elat);
    check(n_ack - tx0 == etx, {rq, " R12 memory transactions"}, n_ack - tx0, etx);
    if (!we) check(got == shadow[a], {rq, " read data"}, int'(got), int'(shadow[a]));
    if (we && !wb_mode) begin
      shadow[a] = d;
      check(mem[a] == d, "R5 memory updated", int'(mem[a]), int'(d));
    end else begin
      if (!hit) begin
        if (vdirty) check(mem[vaddr] == shadow[vaddr], {rq, " victim written back"},
                          int'(mem[vaddr]), int'(shadow[vaddr]));
        m_vld[idx] = 1'b1; m_tag[idx] = tg; m_drt[idx] = 1'b0;
      end
      if (we) begin
        if (hit) check(mem[a] == mem_before, "R8 memory untouched", int'(mem[a]), int'(mem_before));
        m_drt[idx] = 1'b1;
        shadow[a] = d;
      end
    end
  endtask

  initial begin
    #800000;
    n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int lat;
    void'($urandom(32'd4242));
    for (int i = 0; i < 256; i++) begin
      mem[i] = 8'(i * 37 + 11);
      shadow[i] = mem[i];
    end
    for (int i = 0; i < 8; i++) begin
      m_vld[i] = 1'b0; m_drt[i] = 1'b0; m_tag[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(cpu_ready == 1'b0, "R2 ready low after reset", int'(cpu_ready), 0);
    check(mem_req == 1'b0, "R2 no memory request after reset", int'(mem_req), 0);

    // write-through directed sequence on index 3'b110
    wb_mode = 1'b0;
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == M + 1, "R2 first read misses", lat, M + 1);
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == 1, "R3 repeat read hits", lat, 1);
    access(1'b0, 8'h16, 8'h00, lat);
    check(lat == M + 1, "R1 same index other tag misses", lat, M + 1);
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == M + 1, "R1 conflict evicted first tag", lat, M + 1);
    access(1'b0, 8'h17, 8'h00, lat);
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == 1, "R1 other index kept line", lat, 1);
    access(1'b1, 8'hD6, 8'hA5, lat);
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == 1, "R6 write-through hit keeps line valid", lat, 1);
    check(shadow[8'hD6] == 8'hA5, "R6 model holds new value", int'(shadow[8'hD6]), 8'hA5);
    access(1'b1, 8'h16, 8'h3C, lat);
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == 1, "R7 resident line unchanged by write miss", lat, 1);
    access(1'b0, 8'h16, 8'h00, lat);
    check(lat == M + 1, "R7 written address not allocated", lat, M + 1);

    // write-back directed sequence
    wb_mode = 1'b1;
    access(1'b1, 8'h16, 8'h5A, lat);
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == 2 * M + 1, "R9 dirty victim doubles penalty", lat, 2 * M + 1);
    access(1'b1, 8'h5E, 8'hC3, lat);
    check(lat == M + 1, "R10 write miss allocates clean victim", lat, M + 1);
    access(1'b0, 8'h5E, 8'h00, lat);
    check(lat == 1, "R10 allocated line hits", lat, 1);
    wb_mode = 1'b0;
    access(1'b0, 8'hD6, 8'h00, lat);
    check(lat == 2 * M + 1, "R13 leftover dirty line written back", lat, 2 * M + 1);

    // random traffic with policy switches between accesses
    for (int i = 0; i < 600; i++) begin
      logic [7:0] a;
      if ($urandom % 12 == 0) wb_mode = 1'($urandom);
      a = {3'b011, 2'($urandom), 3'($urandom)};
      access(1'($urandom), a, 8'($urandom), lat);
    end

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule